// File: doc/BRIEF.md
# Flash Read Arbiter With Erase Suspend

This block sits between a host read port and the command/data bus of a parallel NOR flash. The host asks for a burst of bus words at a byte address. The block then brings the flash into read-array mode and streams the words back with a valid strobe. How it does that depends on the flash mode reported at `mode_i`. In array mode it reads at once. In status or query mode it polls the ready bit first. While an erase is running, it can pause that erase, serve the read and restart the erase afterwards.

The flash bus has one-cycle operations. A command cycle writes one command byte at the aligned request address. A read cycle returns `rd_data_i`, which is sampled at the end of the same cycle. Each wait for the ready bit is guarded by a cycle budget `TO_CYC`. When the budget runs out, the request ends with an error. If an erase had been paused, the block restarts it before reporting.

Top module: `nor_rd_susp`

## Requirements
- R1: After reset, `cmd_we_o`, `rd_o`, `rsp_valid_o`, `done_o` and `err_o` are all low until a request is accepted.
- R2: With `mode_i` = 0 (read array), an accepted request issues no command and reads `len_i` consecutive bus words. A `len_i` of 0 means 2^LW words. Each word appears on `rsp_data_o` with `rsp_valid_o`, in address order.
- R3: The request address is rounded down to a multiple of DW/8 bytes. Every command address and every burst read address is aligned, and burst word i reads aligned base + i*DW/8.
- R4: With `mode_i` = 1 (status) or 3 (query), the block reads status until bit 7 of `rd_data_i` is 1. It then writes 0xFF exactly once and performs the burst.
- R5: With `mode_i` = 2 (erasing) and `susp_en_i` = 1, the command sequence is 0xB0, 0x70, then status polling, 0xFF, the burst, 0xD0 and 0x70. The request ends without error.
- R6: If the ready bit does not come while an erase is paused, the block writes 0xD0 and then 0x70. It returns no data and ends with `err_o` high.
- R7: If the ready bit does not come in status or query mode, the block ends with `err_o` high, returns no data and writes no command.
- R8: With `mode_i` = 2 and `susp_en_i` = 0, the block issues no flash cycle until `mode_i` leaves 2, and then serves the request according to the new mode.
- R9: Each ready wait allows TO_CYC+1 status reads, and its budget is reloaded at the start of every wait. A wait whose final allowed read shows ready succeeds, even on back-to-back requests.
- R10: `done_o` is a one-cycle pulse, once per request; `err_o` is only high together with `done_o`. A request raised while one is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, accepted when idle |
| addr_i | input | AW | Byte address of the first word |
| len_i | input | LW | Burst length in bus words (0 = 2^LW) |
| mode_i | input | 2 | Flash mode: 0 array, 1 status, 2 erasing, 3 query |
| susp_en_i | input | 1 | Erase suspend allowed |
| cmd_we_o | output | 1 | Command write cycle |
| cmd_addr_o | output | AW | Aligned command address |
| cmd_o | output | 8 | Command byte |
| rd_o | output | 1 | Read cycle (status or array) |
| rd_addr_o | output | AW | Read address |
| rd_data_i | input | DW | Read data, sampled at the end of the read cycle |
| rsp_valid_o | output | 1 | Response word valid |
| rsp_data_o | output | DW | Response word |
| done_o | output | 1 | Request finished (pulse) |
| err_o | output | 1 | Request ended on timeout (with done_o) |

## Verification
The checker assumes that `mode_i` and `susp_en_i` stay constant while a request is in progress. The one exception is that `mode_i` may leave the erasing value while a request waits for the erase to finish. It also assumes that `rd_data_i` is driven during every read cycle. The bench changes mode and suspend enable only between requests, or during the erase wait. Its flash model drives read data half a cycle after the read starts. That model answers status reads with a ready bit that appears after a chosen number of reads, or never.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  typedef enum logic [1:0] {
    FM_ARRAY  = 2'd0,
    FM_STATUS = 2'd1,
    FM_ERASE  = 2'd2,
    FM_QUERY  = 2'd3
  } fmode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_ER, S_SUS_B0, S_SUS_70, S_POLL,
    S_ARRAY, S_BURST, S_RES_D0, S_RES_70, S_DONE
  } st_e;

  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RD_STAT = 8'h70;
  localparam logic [7:0] CMD_RESUME  = 8'hD0;
  localparam logic [7:0] CMD_RD_ARR  = 8'hFF;
  localparam int         RDY_BIT     = 7;
endpackage

// File: rtl/nrs_timer.sv
module nrs_timer #(
  parameter int TO_CYC = 64,
  localparam int TW = $clog2(TO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= TW'(TO_CYC);
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nrs_burst.sv
module nrs_burst #(
  parameter int AW = 24,
  parameter int LW = 4,
  parameter int LB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [LW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_i) idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + 1'b1;
  end

  assign addr_o = base_i + (AW'(idx_q) << LB);
  // len 0 wraps to all ones: full 2^LW burst
  assign last_o = (idx_q == LW'(len_i - 1'b1));
endmodule

// File: rtl/nor_rd_susp.sv
module nor_rd_susp
  import nrs_pkg::*;
#(
  parameter int AW     = 24,
  parameter int DW     = 32,
  parameter int LW     = 4,
  parameter int TO_CYC = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic [1:0]    mode_i,
  input  logic          susp_en_i,
  output logic          cmd_we_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [7:0]    cmd_o,
  output logic          rd_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int NB = DW / 8;
  localparam int LB = $clog2(NB);

  st_e           st_q, st_d, disp_st;
  fmode_e        fm;
  logic [AW-1:0] base_q, brst_addr;
  logic [LW-1:0] len_q;
  logic          susp_q, err_q, rsp_v_q;
  logic [DW-1:0] rsp_d_q;
  logic          tmr_zero, brst_last, rdy;

  assign fm  = fmode_e'(mode_i);
  assign rdy = rd_data_i[RDY_BIT];

  always_comb begin
    unique case (fm)
      FM_ARRAY: disp_st = S_BURST;
      FM_ERASE: disp_st = susp_en_i ? S_SUS_B0 : S_WAIT_ER;
      default:  disp_st = S_POLL;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (req_i) st_d = disp_st;
      S_WAIT_ER: if (fm != FM_ERASE) st_d = disp_st;
      S_SUS_B0:  st_d = S_SUS_70;
      S_SUS_70:  st_d = S_POLL;
      S_POLL: begin
        if (rdy)           st_d = S_ARRAY;
        else if (tmr_zero) st_d = susp_q ? S_RES_D0 : S_DONE;
      end
      S_ARRAY:   st_d = S_BURST;
      S_BURST:   if (brst_last) st_d = susp_q ? S_RES_D0 : S_DONE;
      S_RES_D0:  st_d = S_RES_70;
      S_RES_70:  st_d = S_DONE;
      S_DONE:    st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      base_q  <= '0;
      len_q   <= '0;
      susp_q  <= 1'b0;
      err_q   <= 1'b0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      st_q    <= st_d;
      rsp_v_q <= (st_q == S_BURST);
      if (st_q == S_BURST) rsp_d_q <= rd_data_i;
      if (st_q == S_IDLE && req_i) begin
        base_q <= {addr_i[AW-1:LB], {LB{1'b0}}};
        len_q  <= len_i;
        susp_q <= 1'b0;
        err_q  <= 1'b0;
      end
      if (st_q == S_SUS_70) susp_q <= 1'b1;
      if (st_q == S_POLL && !rdy && tmr_zero) err_q <= 1'b1;
    end
  end

  nrs_timer #(.TO_CYC(TO_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i ((st_d == S_POLL) && (st_q != S_POLL)),
    .en_i   (st_q == S_POLL),
    .zero_o (tmr_zero)
  );

  nrs_burst #(.AW(AW), .LW(LW), .LB(LB)) u_brst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i ((st_d == S_BURST) && (st_q != S_BURST)),
    .step_i  (st_q == S_BURST),
    .base_i  (base_q),
    .len_i   (len_q),
    .addr_o  (brst_addr),
    .last_o  (brst_last)
  );

  always_comb begin
    cmd_we_o = 1'b1;
    unique case (st_q)
      S_SUS_B0: cmd_o = CMD_SUSPEND;
      S_SUS_70: cmd_o = CMD_RD_STAT;
      S_ARRAY:  cmd_o = CMD_RD_ARR;
      S_RES_D0: cmd_o = CMD_RESUME;
      S_RES_70: cmd_o = CMD_RD_STAT;
      default: begin
        cmd_we_o = 1'b0;
        cmd_o    = 8'h00;
      end
    endcase
  end

  assign cmd_addr_o  = base_q;
  assign rd_o        = (st_q == S_POLL) || (st_q == S_BURST);
  assign rd_addr_o   = (st_q == S_BURST) ? brst_addr : base_q;
  assign rsp_valid_o = rsp_v_q;
  assign rsp_data_o  = rsp_d_q;
  assign done_o      = (st_q == S_DONE);
  assign err_o       = (st_q == S_DONE) && err_q;
endmodule

// File: rtl/nrs_chk.sv
module nrs_chk #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          susp_en_i,
  input logic          cmd_we_o,
  input logic [AW-1:0] cmd_addr_o,
  input logic [7:0]    cmd_o,
  input logic          rd_o,
  input logic [AW-1:0] rd_addr_o,
  input logic [DW-1:0] rd_data_i,
  input logic          rsp_valid_o,
  input logic          done_o,
  input logic          err_o
);
  localparam int LB = $clog2(DW / 8);

  a_r5_suspend_then_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_o && cmd_o == 8'hB0) |=> (cmd_we_o && cmd_o == 8'h70));

  a_r6_resume_then_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_o && cmd_o == 8'hD0) |=> (cmd_we_o && cmd_o == 8'h70));

  a_r3_cmd_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |-> (cmd_addr_o[LB-1:0] == '0));

  a_r3_rd_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (rd_addr_o[LB-1:0] == '0));

  a_r4_array_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_o && cmd_o == 8'hFF) |-> $past(rd_o && rd_data_i[7]));

  a_r2_rsp_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(rd_o));

  a_r8_hold_while_erasing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && !susp_en_i) |-> (!rd_o && !cmd_we_o));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r2_single_bus_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_we_o && rd_o));
endmodule

bind nor_rd_susp nrs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .susp_en_i   (susp_en_i),
  .cmd_we_o    (cmd_we_o),
  .cmd_addr_o  (cmd_addr_o),
  .cmd_o       (cmd_o),
  .rd_o        (rd_o),
  .rd_addr_o   (rd_addr_o),
  .rd_data_i   (rd_data_i),
  .rsp_valid_o (rsp_valid_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/nor_rd_susp_tb.sv
module nor_rd_susp_tb;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int LW = 4;
  localparam int TO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] len = '0;
  logic [1:0]    mode = 2'd0;
  logic          susp_en = 1'b0;
  logic          cmd_we, rd, rsp_valid, done, err;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [7:0]    cmd;
  logic [DW-1:0] rd_data, rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 0;

  always #10 clk = ~clk;

  nor_rd_susp #(.AW(AW), .DW(DW), .LW(LW), .TO_CYC(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .len_i(len),
    .mode_i(mode), .susp_en_i(susp_en), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr),
    .cmd_o(cmd), .rd_o(rd), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .done_o(done), .err_o(err)
  );

  // flash model and monitor, on the falling edge
  logic       fl_arr;
  int         st_reads, ready_after = 1;
  logic       cfg_go = 1'b0, cfg_arr = 1'b1;
  logic [7:0] cmd_log [256];
  logic [DW-1:0] rsp_log [256];
  int cmd_n, rd_n, rsp_n, done_n, misalign;
  logic last_err;

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return {8'hA5, a};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      fl_arr <= 1'b1; st_reads <= 0; rd_data <= '0;
      cmd_n <= 0; rd_n <= 0; rsp_n <= 0; done_n <= 0; misalign <= 0; last_err <= 1'b0;
    end else begin
      if (cfg_go) begin fl_arr <= cfg_arr; st_reads <= 0; end
      if (cmd_we) begin
        fl_arr <= (cmd == 8'hFF);
        cmd_log[cmd_n[7:0]] <= cmd;
        cmd_n <= cmd_n + 1;
        if (cmd_addr[1:0] != 2'b00) misalign <= misalign + 1;
      end
      if (rd) begin
        rd_n <= rd_n + 1;
        if (rd_addr[1:0] != 2'b00) misalign <= misalign + 1;
        if (fl_arr) rd_data <= pat(rd_addr);
        else begin
          rd_data  <= (st_reads + 1 >= ready_after) ? 32'h0000_0080 : 32'hFFFF_FF7F;
          st_reads <= st_reads + 1;
        end
      end
      if (rsp_valid) begin rsp_log[rsp_n[7:0]] <= rsp_data; rsp_n <= rsp_n + 1; end
      if (done) begin done_n <= done_n + 1; last_err <= err; end
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic setup(bit arr, int ra, logic [1:0] m, bit se);
    @(posedge clk); #1;
    mode = m; susp_en = se; ready_after = ra; cfg_arr = arr; cfg_go = 1'b1;
    @(posedge clk); #1;
    cfg_go = 1'b0;
  endtask

  task automatic issue(int a, int l);
    @(posedge clk); #1;
    req = 1'b1; addr = AW'(a); len = LW'(l);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic wait_done(int d0, string tag);
    for (int k = 0; k < 300 && done_n == d0; k++) @(posedge clk);
    #1;
    chk(done_n != d0, tag, "request finished", done_n - d0, 1);
  endtask

  // cmds: first command in [7:0]
  task automatic expect_req(string tag, int c0, int r0, int d0, int ncmd,
                            logic [39:0] cmds, int nw, int a, bit e);
    logic [AW-1:0] al;
    al = AW'(a) & ~AW'(3);
    chk(done_n - d0 == 1, tag, "done count", done_n - d0, 1);
    chk(last_err == e, tag, "error flag", last_err, e);
    chk(cmd_n - c0 == ncmd, tag, "command count", cmd_n - c0, ncmd);
    for (int i = 0; i < ncmd && i < cmd_n - c0; i++)
      chk(cmd_log[(c0 + i) % 256] == cmds[8*i +: 8], tag, "command byte",
          cmd_log[(c0 + i) % 256], cmds[8*i +: 8]);
    chk(rsp_n - r0 == nw, tag, "word count", rsp_n - r0, nw);
    for (int i = 0; i < nw && i < rsp_n - r0; i++)
      chk(rsp_log[(r0 + i) % 256] == pat(al + AW'(4 * i)), tag, "data word",
          rsp_log[(r0 + i) % 256], pat(al + AW'(4 * i)));
    chk(misalign == 0, tag, "misaligned flash cycles", misalign, 0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(!cmd_we && !rd && !rsp_valid && !done && !err, "R1", "idle outputs",
          {cmd_we, rd, rsp_valid, done, err}, 0);
    end
  endtask

  task automatic t_array(int a, int l, int nw, string tag);
    int c0, r0, d0;
    setup(1'b1, 1, 2'd0, 1'b0);
    c0 = cmd_n; r0 = rsp_n; d0 = done_n;
    issue(a, l);
    wait_done(d0, tag);
    expect_req(tag, c0, r0, d0, 0, 40'h0, nw, a, 1'b0);
  endtask

  task automatic t_status(logic [1:0] m, int ra, string tag);
    int c0, r0, d0, q0;
    setup(1'b0, ra, m, 1'b0);
    c0 = cmd_n; r0 = rsp_n; d0 = done_n; q0 = rd_n;
    issue(32'h400, 2);
    wait_done(d0, tag);
    expect_req(tag, c0, r0, d0, 1, 40'hFF, 2, 32'h400, 1'b0);
    chk(rd_n - q0 == ra + 2, tag, "flash read cycles", rd_n - q0, ra + 2);
  endtask

  task automatic t_suspend();
    int c0, r0, d0;
    setup(1'b0, 4, 2'd2, 1'b1);
    c0 = cmd_n; r0 = rsp_n; d0 = done_n;
    issue(32'h8010, 3);
    wait_done(d0, "R5");
    expect_req("R5", c0, r0, d0, 5, 40'h70_D0_FF_70_B0, 3, 32'h8010, 1'b0);
  endtask

  task automatic t_timeout(bit susp, string tag);
    int c0, r0, d0, q0;
    setup(1'b0, 1000, susp ? 2'd2 : 2'd1, susp);
    c0 = cmd_n; r0 = rsp_n; d0 = done_n; q0 = rd_n;
    issue(32'h900, 2);
    wait_done(d0, tag);
    if (susp) expect_req(tag, c0, r0, d0, 4, 40'h70_D0_70_B0, 0, 32'h900, 1'b1);
    else      expect_req(tag, c0, r0, d0, 0, 40'h0, 0, 32'h900, 1'b1);
    chk(rd_n - q0 == TO + 1, tag, "status reads before timeout", rd_n - q0, TO + 1);
  endtask

  task automatic t_no_suspend();
    int c0, r0, d0, q0;
    setup(1'b0, 2, 2'd2, 1'b0);
    c0 = cmd_n; r0 = rsp_n; d0 = done_n; q0 = rd_n;
    issue(32'hA00, 2);
    repeat (20) @(posedge clk);
    #1;
    chk(cmd_n == c0 && rd_n == q0, "R8", "flash cycles while erasing",
        (cmd_n - c0) + (rd_n - q0), 0);
    chk(done_n == d0, "R8", "done while erasing", done_n - d0, 0);
    mode = 2'd1;
    wait_done(d0, "R8");
    expect_req("R8", c0, r0, d0, 1, 40'hFF, 2, 32'hA00, 1'b0);
    chk(rd_n - q0 == 4, "R8", "flash read cycles", rd_n - q0, 4);
  endtask

  task automatic t_busy_ignore();
    int c0, r0, d0;
    setup(1'b1, 1, 2'd0, 1'b0);
    c0 = cmd_n; r0 = rsp_n; d0 = done_n;
    issue(32'h5000, 6);
    @(posedge clk); #1;
    req = 1'b1; addr = AW'(32'h6000); len = LW'(2);
    @(posedge clk); #1;
    req = 1'b0;
    wait_done(d0, "R10");
    repeat (10) @(posedge clk);
    #1;
    expect_req("R10", c0, r0, d0, 0, 40'h0, 6, 32'h5000, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    t_reset();
    t_array(32'h1000, 4, 4, "R2");
    t_array(32'h3000, 0, 16, "R2");
    t_array(32'h2007, 3, 3, "R3");
    t_status(2'd1, 3, "R4");
    t_status(2'd3, 1, "R4");
    t_suspend();
    t_timeout(1'b1, "R6");
    t_timeout(1'b0, "R7");
    t_no_suspend();
    t_status(2'd1, TO + 1, "R9");
    t_status(2'd1, TO + 1, "R9");
    t_busy_ignore();
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule